// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This controller drives the active-low reset of a processor from three causes: a digital flag that says the supply is under its threshold, an active-low manual reset request, and a watchdog that expects the software to keep toggling a service line. Every reset, whatever its cause, is stretched by a fixed number of clock ticks after the cause goes away. All timeouts are parameters counted in clock ticks.

The watchdog service line has a level and a separate "floating" flag. While the line floats, an internal self-service driver stands in for it. This driver holds low for seven eighths of the watchdog timeout and then goes high for one tick, so an unconnected line never trips the watchdog. The manual and watchdog inputs pass through a two-flop synchroniser. The supply flag is taken as already synchronous.

The core is a three-state machine. ST_HOLD keeps reset asserted while a hold cause is present. ST_STRETCH counts the stretch timeout with reset still asserted. ST_RUN releases reset and lets the watchdog count. The transitions are:
- HOLD_ENTER: any state goes to ST_HOLD when the supply flag is set or the synchronised manual input is low.
- HOLD_LEAVE: ST_HOLD goes to ST_STRETCH with the count at zero once no hold cause remains.
- STRETCH_DONE: ST_STRETCH goes to ST_RUN after STRETCH_TICKS cycles.
- WD_TRIP: ST_RUN goes to ST_STRETCH with the count at zero when the watchdog expires.

Power-on reset puts the machine in ST_HOLD.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, `sys_rst_n` is 0. After `rst_n` rises with no cause present, `sys_rst_n` stays 0 for exactly STRETCH_TICKS clock cycles, counted from the first rising edge after release, and then goes to 1.
- R2: While `supply_low` is 1, `sys_rst_n` is 0 from the next clock edge onward. After `supply_low` returns to 0, `sys_rst_n` stays 0 for exactly STRETCH_TICKS further cycles.
- R3: If `supply_low` is set again during a stretch, the stretch count restarts from zero. The full STRETCH_TICKS cycles are counted again after the flag clears.
- R4: While `man_rst_n` is 0, `sys_rst_n` is 0. After `man_rst_n` returns to 1, `sys_rst_n` stays 0 for STRETCH_TICKS+2 cycles: two cycles of synchroniser delay plus the stretch.
- R5: With the service line driven (`wd_float`=0) at a constant level, `sys_rst_n` stays 1 for exactly WD_TICKS cycles after release. It then drops for exactly STRETCH_TICKS cycles. This holds for a constant level of 0 and of 1.
- R6: A rising or a falling edge on `wd_level` clears the watchdog count. This includes a pulse only one clock period wide.
- R7: The watchdog count is held at zero and does not advance while reset is asserted. A reset longer than the watchdog timeout is still followed by a full WD_TICKS cycles with reset released.
- R8: While `wd_float` is 1, the self-service driver stops the watchdog from expiring. Its period is WD_TICKS*7/8 low cycles followed by one high cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| supply_low | input | 1 | Supply under threshold flag, synchronous |
| man_rst_n | input | 1 | Manual reset request, active low, asynchronous |
| wd_level | input | 1 | Watchdog service line level, asynchronous |
| wd_float | input | 1 | Service line is floating (1) or driven (0), asynchronous |
| sys_rst_n | output | 1 | Stretched reset to the processor, active low |

## Verification
The bench measures the exact lengths of the low and high runs of the reset output, so a stretch that is one cycle off fails. It targets the following corner cases:
- Supply re-drop in mid-stretch: a design that kept counting instead of restarting would release early.
- Reset held much longer than the watchdog timeout: a watchdog that kept counting during reset would fire at once after release.
- Single-cycle service pulses: a design that only saw one edge direction, or that missed short pulses, would trip.
- Floating line: a missing or slow self-service pulse would let the watchdog fire.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } sup_state_e;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int          WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[b] <= RST_VAL[b];
                sync_q[b] <= RST_VAL[b];
            end else begin
                meta_q[b] <= async_in[b];
                sync_q[b] <= meta_q[b];
            end
        end
    end

    assign sync_out = sync_q;

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
    parameter int WD_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_level,
    input  logic wd_float,
    input  logic hold_clear,
    output logic trip
);

    localparam int WD_W   = (WD_TICKS > 2) ? $clog2(WD_TICKS) : 1;
    localparam int SV_LOW = (WD_TICKS * 7) / 8;
    localparam int SV_W   = (SV_LOW > 1) ? $clog2(SV_LOW + 1) : 1;
    localparam logic [WD_W-1:0] WD_LAST = WD_W'(WD_TICKS - 1);
    localparam logic [SV_W-1:0] SV_HIGH = SV_W'(SV_LOW);

    logic [SV_W-1:0] sv_cnt;
    logic            self_drv;
    logic            eff_level;
    logic            prev_level;
    logic            edge_seen;
    logic [WD_W-1:0] wd_cnt;

    // self-service driver: low for SV_LOW ticks, then high for one tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sv_cnt <= '0;
        end else if (hold_clear || sv_cnt == SV_HIGH) begin
            sv_cnt <= '0;
        end else begin
            sv_cnt <= sv_cnt + 1'b1;
        end
    end

    assign self_drv  = (sv_cnt == SV_HIGH);
    assign eff_level = wd_float ? self_drv : wd_level;
    assign edge_seen = eff_level ^ prev_level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_level <= 1'b0;
        end else begin
            prev_level <= eff_level;
        end
    end

    assign trip = !hold_clear && !edge_seen && (wd_cnt == WD_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_cnt <= '0;
        end else if (hold_clear || edge_seen || trip) begin
            wd_cnt <= '0;
        end else begin
            wd_cnt <= wd_cnt + 1'b1;
        end
    end

    assert_wd_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clear |=> (wd_cnt == '0));

    assert_edge_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && !hold_clear) |=> (wd_cnt == '0) && !trip);

    assert_self_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
        self_drv |=> !self_drv);

endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
    import sup_pkg::*;
#(
    parameter int STRETCH_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic wd_trip,
    output logic rst_out_n,
    output logic hold_clear
);

    localparam int S_W = (STRETCH_TICKS > 2) ? $clog2(STRETCH_TICKS) : 1;
    localparam logic [S_W-1:0] S_LAST = S_W'(STRETCH_TICKS - 1);

    sup_state_e     state, state_nxt;
    logic [S_W-1:0] cnt, cnt_nxt;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        if (hold_req) begin
            state_nxt = ST_HOLD;
            cnt_nxt   = '0;
        end else begin
            unique case (state)
                ST_HOLD: begin
                    state_nxt = ST_STRETCH;
                    cnt_nxt   = '0;
                end
                ST_STRETCH: begin
                    if (cnt == S_LAST) begin
                        state_nxt = ST_RUN;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (wd_trip) begin
                        state_nxt = ST_STRETCH;
                        cnt_nxt   = '0;
                    end
                end
                default: begin
                    state_nxt = ST_HOLD;
                    cnt_nxt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HOLD;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        rst_out_n  = (state == ST_RUN);
        hold_clear = (state != ST_RUN);
    end

    assert_hold_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |=> !rst_out_n);

    assert_full_stretch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> ($past(state) == ST_STRETCH) && ($past(cnt) == S_LAST));

    assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !hold_req) |=> (state == ST_STRETCH) && (cnt == '0));

    assert_trip_stretch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && wd_trip && !hold_req) |=> (state == ST_STRETCH) && (cnt == '0));

endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
    parameter int STRETCH_TICKS = 20,
    parameter int WD_TICKS      = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    input  logic man_rst_n,
    input  logic wd_level,
    input  logic wd_float,
    output logic sys_rst_n
);

    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] synced;
    logic              man_s, level_s, float_s;
    logic              hold_req;
    logic              hold_clear;
    logic              wd_trip;

    assign raw_in = {man_rst_n, wd_level, wd_float};

    sup_sync #(
        .WIDTH   (SYNC_W),
        .RST_VAL (3'b100)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (synced)
    );

    assign {man_s, level_s, float_s} = synced;
    assign hold_req = supply_low || !man_s;

    sup_wdog #(
        .WD_TICKS (WD_TICKS)
    ) i_wdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .wd_level   (level_s),
        .wd_float   (float_s),
        .hold_clear (hold_clear),
        .trip       (wd_trip)
    );

    sup_fsm #(
        .STRETCH_TICKS (STRETCH_TICKS)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_req   (hold_req),
        .wd_trip    (wd_trip),
        .rst_out_n  (sys_rst_n),
        .hold_clear (hold_clear)
    );

    assert_manual_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !man_s |=> !sys_rst_n);

endmodule

// File: tb/test_sup_reset_ctrl.sv
module test_sup_reset_ctrl;

    localparam int S  = 20;
    localparam int WD = 64;

    logic clk = 1'b0;
    logic rst_n, supply_low, man_rst_n, wd_level, wd_float;
    logic sys_rst_n;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    sup_reset_ctrl #(.STRETCH_TICKS(S), .WD_TICKS(WD)) i_sup_reset_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_low (supply_low),
        .man_rst_n  (man_rst_n),
        .wd_level   (wd_level),
        .wd_float   (wd_float),
        .sys_rst_n  (sys_rst_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // counts consecutive negedge samples equal to lvl, starting with the current one
    task automatic run_len(input logic lvl, input int cap, output int n);
        n = 0;
        while (sys_rst_n === lvl && n < cap) begin
            n++;
            @(negedge clk);
        end
    endtask

    // counts samples at a level over a fixed window
    task automatic count_level(input logic lvl, input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            if (sys_rst_n === lvl) n++;
            @(negedge clk);
        end
    endtask

    task automatic t_por_r1;
        int n;
        check(sys_rst_n === 1'b0, "R1 low in reset", int'(sys_rst_n), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_len(1'b0, 1000, n);
        check(n == S, "R1 stretch after power-on", n, S);
        run_len(1'b1, 1000, n);
        check(n == WD, "R5 watchdog at level 0", n, WD);
        run_len(1'b0, 1000, n);
        check(n == S, "R5 stretch after trip", n, S);
    endtask

    task automatic t_supply_r2;
        int n;
        supply_low = 1'b1;
        @(negedge clk);
        count_level(1'b0, 10, n);
        check(n == 10, "R2 low while supply flag set", n, 10);
        supply_low = 1'b0;
        @(negedge clk);
        run_len(1'b0, 1000, n);
        check(n == S, "R2 stretch after supply", n, S);
    endtask

    task automatic t_restart_r3;
        int n;
        supply_low = 1'b1;
        repeat (5) @(negedge clk);
        supply_low = 1'b0;
        repeat (6) @(negedge clk);
        supply_low = 1'b1;
        repeat (2) @(negedge clk);
        supply_low = 1'b0;
        @(negedge clk);
        run_len(1'b0, 1000, n);
        check(n == S, "R3 stretch restarts", n, S);
    endtask

    task automatic t_manual_r4;
        int n;
        man_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        count_level(1'b0, 10, n);
        check(n == 10, "R4 low while manual held", n, 10);
        man_rst_n = 1'b1;
        @(negedge clk);
        run_len(1'b0, 1000, n);
        check(n == S + 2, "R4 stretch after manual", n, S + 2);
    endtask

    task automatic t_edges_r6;
        int n;
        int lows = 0;
        for (int k = 0; k < 6; k++) begin
            count_level(1'b0, WD - 8, n);
            lows += n;
            wd_level = ~wd_level;
        end
        check(lows == 0, "R6 level toggles service", lows, 0);
        wd_level = 1'b0;
        lows = 0;
        for (int k = 0; k < 6; k++) begin
            count_level(1'b0, WD - 8, n);
            lows += n;
            wd_level = 1'b1;
            @(negedge clk);
            wd_level = 1'b0;
        end
        count_level(1'b0, 4, n);
        lows += n;
        check(lows == 0, "R6 one-cycle pulses service", lows, 0);
    endtask

    task automatic t_held_r7;
        int n;
        supply_low = 1'b1;
        @(negedge clk);
        count_level(1'b1, 3 * WD, n);
        check(n == 0, "R7 no release during long reset", n, 0);
        supply_low = 1'b0;
        @(negedge clk);
        run_len(1'b0, 1000, n);
        check(n == S, "R7 stretch after long reset", n, S);
        run_len(1'b1, 1000, n);
        check(n == WD, "R7 full watchdog window after reset", n, WD);
        run_len(1'b0, 1000, n);
        check(n == S, "R5 stretch after second trip", n, S);
    endtask

    task automatic t_float_r8;
        int n;
        wd_float = 1'b1;
        count_level(1'b0, 5 * WD, n);
        check(n == 0, "R8 floating line self-served", n, 0);
        wd_float = 1'b0;
        wd_level = 1'b1;
        run_len(1'b1, 1000, n);
        check(n <= WD + 4 && n >= WD - 60, "R5 trip at level 1", n, WD);
        run_len(1'b0, 1000, n);
        check(n == S, "R5 stretch after level 1 trip", n, S);
        run_len(1'b1, 1000, n);
        check(n == WD, "R5 watchdog window at level 1", n, WD);
    endtask

    initial begin
        rst_n      = 1'b0;
        supply_low = 1'b0;
        man_rst_n  = 1'b1;
        wd_level   = 1'b0;
        wd_float   = 1'b0;
        repeat (4) @(negedge clk);
        t_por_r1();
        t_supply_r2();
        t_restart_r3();
        t_manual_r4();
        t_edges_r6();
        t_held_r7();
        t_float_r8();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule